// File: doc/BRIEF.md
# Command/Reply Transaction Sequencer

This block runs complete command/reply transactions with a power-management controller over a byte-wide link. A host-side producer queues requests (an opcode, a byte count and up to 32 payload bytes). The sequencer transmits the opcode, then optionally an explicit length byte, then the payload. It then collects a reply whose size is either fixed or carried in the first received byte. Send and receive sizes come from an external per-opcode lookup, in which the value 0xFF (-1) means "a length byte travels on the link".

The controller can also raise an attention line at any time. The sequencer remembers the rising edge. The next time it reaches idle, it transmits an interrupt-acknowledge opcode and reads back a length-prefixed interrupt packet. A serviced attention always goes ahead of queued requests.

Some requests are marked as deferred. Their answer does not come as a direct reply. It comes later, inside an interrupt packet, and the sequencer routes that packet to the waiting request instead of the interrupt output.

Top module: `xact_seq`

## Requirements
- R1: After reset, link_go, done_valid and irq_valid are low, req_ready is high and stray_reply is low.
- R2: The opcode is the first byte transmitted (link_dir=1). When the send size from the lookup is a non-negative count, the payload bytes follow the opcode directly, payload byte k taken from req_data bits [8k+7:8k].
- R3: When the send size is 0xFF, the byte after the opcode is req_nbytes-1, followed by the payload bytes.
- R4: A request is rejected at intake in three cases: req_nbytes is 0, req_nbytes exceeds 33, or the send size is non-negative and req_nbytes differs from size+1. A rejected request raises done_valid with done_status=1 and done_len=0, and transmits nothing.
- R5: After the last transmitted byte, a receive size of 0 gives done_status=0 and done_len=0. A positive receive size reads exactly that many bytes, returned with byte k at done_data bits [8k+7:8k].
- R6: A receive size of 0xFF makes the first received byte the reply length. The bytes that follow are the reply.
- R7: A reply length above 32 gives done_status=2 and done_len=32. Every announced byte is still taken from the link.
- R8: A rising edge on attn makes the sequencer transmit IACK_OP (default 0x78) and read a length-prefixed packet. The packet appears on irq_valid/irq_len/irq_data.
- R9: When the sequencer is idle, a pending attention is served before any queued request.
- R10: Requests are held in a 4-entry queue and executed in arrival order. req_ready is low while the queue is full.
- R11: A deferred request whose receive size is 0 completes only when a packet arrives whose first byte has bit 4 (0x10) set and bit 2 (0x04) clear. A later deferred request is not started while one is waiting.
- R12: The deferred reply is the packet without its first byte. A packet of 2 bytes or fewer gives done_len=0.
- R13: A deferred-reply packet that arrives while no request is waiting is discarded. It sets the sticky stray_reply output and produces neither done_valid nor irq_valid.
- R14: A packet with bit 2 set or bit 4 clear in its first byte goes to the interrupt output, even while a deferred request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 8 | Request opcode |
| req_nbytes | input | 6 | Bytes in request including opcode |
| req_data | input | 256 | Payload, byte k at bits [8k+7:8k] |
| req_deferred | input | 1 | Reply arrives later through an interrupt packet |
| chk_op | output | 8 | Opcode looked up for the intake check |
| chk_send | input | 8 | Send size for chk_op (0xFF = length byte) |
| tbl_op | output | 8 | Opcode looked up by the sequencer |
| tbl_send | input | 8 | Send size for tbl_op |
| tbl_recv | input | 8 | Receive size for tbl_op (0xFF = length byte) |
| attn | input | 1 | Asynchronous attention request |
| link_go | output | 1 | One-cycle start of a link byte transfer |
| link_dir | output | 1 | 1 = transmit link_tx, 0 = receive |
| link_tx | output | 8 | Byte to transmit |
| link_ack | input | 1 | Transfer finished pulse |
| link_rx | input | 8 | Received byte, valid with link_ack |
| done_valid | output | 1 | Request completed pulse |
| done_status | output | 2 | 0 ok, 1 length error, 2 overlong reply |
| done_len | output | 6 | Reply length |
| done_data | output | 256 | Reply bytes |
| irq_valid | output | 1 | Interrupt packet pulse |
| irq_len | output | 6 | Packet length (capped at 32) |
| irq_ovf | output | 1 | Packet announced more than 32 bytes |
| irq_data | output | 256 | Packet bytes |
| stray_reply | output | 1 | Sticky: unexpected deferred reply seen |

## Verification
A corrupted byte index or length register shows up as a wrong byte on link_tx within the same transaction. It also desynchronises later link reads, so a following reply or packet comes back with the wrong bytes. A lost attention flag or deferred-wait flag shows up as a missing or reordered IACK_OP on the link, or as a deferred reply routed to irq_valid instead of done_valid, once the next packet arrives. An intake check that is wrong shows up in the cycle after acceptance, as a missing or spurious length-error completion.

// File: rtl/xact_pkg.sv
package xact_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_IACK, ST_RREP, ST_RINT
  } xact_st_e;

  typedef enum logic [1:0] {
    DS_OK  = 2'd0,
    DS_LEN = 2'd1,
    DS_OVF = 2'd2
  } xact_ds_e;
endpackage

// File: rtl/xact_fifo.sv
module xact_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         vld,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign vld  = (cnt != '0);
  assign full = (cnt == CW'(DEPTH));
  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/xact_sync_edge.sv
module xact_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      rise <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-1:0], din};
      rise <= sh[STAGES-1] & ~sh[STAGES];
    end
  end
endmodule

// File: rtl/xact_core.sv
module xact_core
  import xact_pkg::*;
#(
  parameter int          MAX_DATA  = 32,
  parameter logic [7:0]  IACK_OP   = 8'h78,
  parameter logic [7:0]  EVT_MASK  = 8'h10,
  parameter logic [7:0]  AUTO_MASK = 8'h04,
  localparam int DW  = 8 * MAX_DATA,
  localparam int NBW = $clog2(MAX_DATA + 2),
  localparam int LW  = $clog2(MAX_DATA + 1),
  localparam int IW  = $clog2(MAX_DATA)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           head_vld,
  input  logic [7:0]     head_op,
  input  logic [NBW-1:0] head_nd,
  input  logic [DW-1:0]  head_data,
  input  logic           head_def,
  output logic           pop,
  output logic [7:0]     tbl_op,
  input  logic [7:0]     tbl_send,
  input  logic [7:0]     tbl_recv,
  input  logic           attn_rise,
  input  logic           rej,
  output logic           link_go,
  output logic           link_dir,
  output logic [7:0]     link_tx,
  input  logic           link_ack,
  input  logic [7:0]     link_rx,
  output logic           done_valid,
  output logic [1:0]     done_status,
  output logic [LW-1:0]  done_len,
  output logic [DW-1:0]  done_data,
  output logic           irq_valid,
  output logic [LW-1:0]  irq_len,
  output logic           irq_ovf,
  output logic [DW-1:0]  irq_data,
  output logic           stray_reply
);
  xact_st_e        st;
  logic            pend, awaiting, need_lb, cur_def, lenk, ovf;
  logic [NBW-1:0]  cur_nd, di;
  logic [DW-1:0]   cur_data;
  logic [7:0]      recv_len, rlen, rc;
  logic [7:0]      rbuf [MAX_DATA];

  logic            can_start, rd_st, fin, is_defrep;
  logic [7:0]      rc1, pkt_b0;
  logic [LW-1:0]   fin_len, def_len;
  logic [DW-1:0]   base_flat, flat_n;

  // reply buffer viewed as one vector
  for (genvar j = 0; j < MAX_DATA; j++) begin : g_flat
    assign base_flat[8*j +: 8] = rbuf[j];
  end

  always_comb begin
    can_start = head_vld && !(head_def && awaiting);
    tbl_op    = head_op;
    pop       = (st == ST_IDLE) && !pend && can_start;
    rd_st     = (st == ST_RREP) || (st == ST_RINT);
    rc1       = rc + 8'd1;
    fin       = link_ack && rd_st && (lenk ? (rc1 >= rlen) : (link_rx == 8'd0));
    if (!lenk)                       fin_len = '0;
    else if (32'(rc1) > MAX_DATA)    fin_len = LW'(MAX_DATA);
    else                             fin_len = LW'(rc1);
    // include the byte arriving in this cycle
    flat_n = base_flat;
    if (lenk && 32'(rc) < MAX_DATA) flat_n[8*rc[IW-1:0] +: 8] = link_rx;
    pkt_b0    = flat_n[7:0];
    is_defrep = (fin_len != '0) && ((pkt_b0 & EVT_MASK) != 8'd0)
                && ((pkt_b0 & AUTO_MASK) == 8'd0);
    def_len   = (fin_len <= LW'(2)) ? '0 : fin_len - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (link_ack && rd_st && lenk && 32'(rc) < MAX_DATA)
      rbuf[rc[IW-1:0]] <= link_rx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      pend        <= 1'b0;
      awaiting    <= 1'b0;
      need_lb     <= 1'b0;
      cur_def     <= 1'b0;
      lenk        <= 1'b0;
      ovf         <= 1'b0;
      cur_nd      <= '0;
      di          <= '0;
      cur_data    <= '0;
      recv_len    <= '0;
      rlen        <= '0;
      rc          <= '0;
      link_go     <= 1'b0;
      link_dir    <= 1'b0;
      link_tx     <= '0;
      done_valid  <= 1'b0;
      done_status <= DS_OK;
      done_len    <= '0;
      done_data   <= '0;
      irq_valid   <= 1'b0;
      irq_len     <= '0;
      irq_ovf     <= 1'b0;
      irq_data    <= '0;
      stray_reply <= 1'b0;
    end else begin
      link_go    <= 1'b0;
      done_valid <= 1'b0;
      irq_valid  <= 1'b0;
      if (attn_rise) pend <= 1'b1;
      if (rej) begin
        done_valid  <= 1'b1;
        done_status <= DS_LEN;
        done_len    <= '0;
        done_data   <= '0;
      end
      unique case (st)
        ST_IDLE: begin
          if (pend) begin
            pend     <= attn_rise;
            link_go  <= 1'b1;
            link_dir <= 1'b1;
            link_tx  <= IACK_OP;
            st       <= ST_IACK;
          end else if (can_start) begin
            cur_nd   <= head_nd;
            cur_data <= head_data;
            cur_def  <= head_def;
            need_lb  <= ($signed(tbl_send) < 0);
            recv_len <= tbl_recv;
            di       <= '0;
            link_go  <= 1'b1;
            link_dir <= 1'b1;
            link_tx  <= head_op;
            st       <= ST_SEND;
          end
        end
        ST_SEND: if (link_ack) begin
          if (need_lb) begin
            need_lb  <= 1'b0;
            link_go  <= 1'b1;
            link_tx  <= 8'(cur_nd);
          end else if (di < cur_nd) begin
            di       <= di + NBW'(1);
            link_go  <= 1'b1;
            link_tx  <= cur_data[8*di +: 8];
          end else if (recv_len == 8'd0) begin
            st <= ST_IDLE;
            if (cur_def) awaiting <= 1'b1;
            else begin
              done_valid  <= 1'b1;
              done_status <= DS_OK;
              done_len    <= '0;
              done_data   <= '0;
            end
          end else begin
            lenk     <= !recv_len[7];
            rlen     <= recv_len;
            rc       <= '0;
            ovf      <= !recv_len[7] && (32'(recv_len) > MAX_DATA);
            link_go  <= 1'b1;
            link_dir <= 1'b0;
            link_tx  <= '0;
            st       <= ST_RREP;
          end
        end
        ST_IACK: if (link_ack) begin
          lenk     <= 1'b0;
          rc       <= '0;
          ovf      <= 1'b0;
          link_go  <= 1'b1;
          link_dir <= 1'b0;
          link_tx  <= '0;
          st       <= ST_RINT;
        end
        ST_RREP, ST_RINT: if (link_ack) begin
          if (fin) begin
            st <= ST_IDLE;
            if (st == ST_RREP) begin
              done_valid  <= 1'b1;
              done_status <= ovf ? DS_OVF : DS_OK;
              done_len    <= fin_len;
              done_data   <= flat_n;
            end else if (is_defrep) begin
              if (awaiting) begin
                awaiting    <= 1'b0;
                done_valid  <= 1'b1;
                done_status <= DS_OK;
                done_len    <= def_len;
                done_data   <= (def_len == '0) ? '0 : (flat_n >> 8);
              end else begin
                stray_reply <= 1'b1;
              end
            end else begin
              irq_valid <= 1'b1;
              irq_len   <= fin_len;
              irq_ovf   <= ovf;
              irq_data  <= flat_n;
            end
          end else begin
            if (!lenk) begin
              lenk <= 1'b1;
              rlen <= link_rx;
              ovf  <= (32'(link_rx) > MAX_DATA);
            end else begin
              rc <= rc1;
            end
            link_go  <= 1'b1;
            link_dir <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xact_seq.sv
module xact_seq #(
  parameter int         MAX_DATA    = 32,
  parameter int         QDEPTH      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] IACK_OP     = 8'h78,
  parameter logic [7:0] EVT_MASK    = 8'h10,
  parameter logic [7:0] AUTO_MASK   = 8'h04,
  localparam int DW  = 8 * MAX_DATA,
  localparam int NBW = $clog2(MAX_DATA + 2),
  localparam int LW  = $clog2(MAX_DATA + 1),
  localparam int EW  = 1 + NBW + 8 + DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [7:0]     req_op,
  input  logic [NBW-1:0] req_nbytes,
  input  logic [DW-1:0]  req_data,
  input  logic           req_deferred,
  output logic [7:0]     chk_op,
  input  logic [7:0]     chk_send,
  output logic [7:0]     tbl_op,
  input  logic [7:0]     tbl_send,
  input  logic [7:0]     tbl_recv,
  input  logic           attn,
  output logic           link_go,
  output logic           link_dir,
  output logic [7:0]     link_tx,
  input  logic           link_ack,
  input  logic [7:0]     link_rx,
  output logic           done_valid,
  output logic [1:0]     done_status,
  output logic [LW-1:0]  done_len,
  output logic [DW-1:0]  done_data,
  output logic           irq_valid,
  output logic [LW-1:0]  irq_len,
  output logic           irq_ovf,
  output logic [DW-1:0]  irq_data,
  output logic           stray_reply
);
  logic          q_full, q_vld, q_pop, q_push, rej, bad, attn_rise, take;
  logic [EW-1:0] q_din, q_dout;

  assign chk_op    = req_op;
  assign req_ready = !q_full && !link_ack;
  assign take      = req_valid && req_ready;
  assign bad       = (req_nbytes == '0) || (32'(req_nbytes) > MAX_DATA + 1) ||
                     (($signed(chk_send) >= 0) &&
                      (32'(req_nbytes) != 32'(chk_send) + 32'd1));
  assign q_push    = take && !bad;
  assign rej       = take && bad;
  assign q_din     = {req_deferred, req_nbytes - NBW'(1), req_op, req_data};

  xact_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_dout), .vld(q_vld), .full(q_full)
  );

  xact_sync_edge #(.STAGES(SYNC_STAGES)) u_attn (
    .clk(clk), .rst(rst), .din(attn), .rise(attn_rise)
  );

  xact_core #(
    .MAX_DATA(MAX_DATA), .IACK_OP(IACK_OP),
    .EVT_MASK(EVT_MASK), .AUTO_MASK(AUTO_MASK)
  ) u_core (
    .clk(clk), .rst(rst),
    .head_vld(q_vld),
    .head_op(q_dout[DW +: 8]),
    .head_nd(q_dout[DW+8 +: NBW]),
    .head_data(q_dout[DW-1:0]),
    .head_def(q_dout[EW-1]),
    .pop(q_pop),
    .tbl_op(tbl_op), .tbl_send(tbl_send), .tbl_recv(tbl_recv),
    .attn_rise(attn_rise), .rej(rej),
    .link_go(link_go), .link_dir(link_dir), .link_tx(link_tx),
    .link_ack(link_ack), .link_rx(link_rx),
    .done_valid(done_valid), .done_status(done_status),
    .done_len(done_len), .done_data(done_data),
    .irq_valid(irq_valid), .irq_len(irq_len), .irq_ovf(irq_ovf),
    .irq_data(irq_data), .stray_reply(stray_reply)
  );
endmodule

// File: rtl/xact_chk.sv
module xact_chk #(
  parameter int MAX_DATA = 32,
  localparam int LW = $clog2(MAX_DATA + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          link_go,
  input logic          done_valid,
  input logic [1:0]    done_status,
  input logic [LW-1:0] done_len,
  input logic          irq_valid,
  input logic [LW-1:0] irq_len,
  input logic          stray_reply
);
  // R2
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    link_go |=> !link_go);

  // R4
  rej_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_status == 2'd1) |-> (done_len == '0));

  // R7
  ovf_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_status == 2'd2) |-> (done_len == LW'(MAX_DATA)));

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid || irq_valid) |-> (done_len <= LW'(MAX_DATA) && irq_len <= LW'(MAX_DATA)));

  // R13
  stray_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stray_reply |=> stray_reply);

  // R14
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && irq_valid));
endmodule

bind xact_seq xact_chk #(.MAX_DATA(MAX_DATA)) u_chk (
  .clk(clk), .rst(rst), .link_go(link_go),
  .done_valid(done_valid), .done_status(done_status), .done_len(done_len),
  .irq_valid(irq_valid), .irq_len(irq_len), .stray_reply(stray_reply)
);

// File: tb/tb_xact_seq.sv
`timescale 1ns/1ps
module tb_xact_seq;
  localparam int MAX = 32;
  localparam int DW  = 8 * MAX;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_deferred = 1'b0, attn = 1'b0;
  logic          req_ready, link_go, link_dir, done_valid, irq_valid, irq_ovf, stray_reply;
  logic [7:0]    req_op = '0, chk_op, chk_send, tbl_op, tbl_send, tbl_recv, link_tx;
  logic [5:0]    req_nbytes = '0, done_len, irq_len;
  logic [DW-1:0] req_data = '0, done_data, irq_data;
  logic          link_ack = 1'b0;
  logic [7:0]    link_rx = '0;
  logic [1:0]    done_status;

  xact_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_nbytes(req_nbytes), .req_data(req_data),
    .req_deferred(req_deferred), .chk_op(chk_op), .chk_send(chk_send),
    .tbl_op(tbl_op), .tbl_send(tbl_send), .tbl_recv(tbl_recv), .attn(attn),
    .link_go(link_go), .link_dir(link_dir), .link_tx(link_tx),
    .link_ack(link_ack), .link_rx(link_rx), .done_valid(done_valid),
    .done_status(done_status), .done_len(done_len), .done_data(done_data),
    .irq_valid(irq_valid), .irq_len(irq_len), .irq_ovf(irq_ovf),
    .irq_data(irq_data), .stray_reply(stray_reply)
  );

  // per-opcode sizes, 0xFF = length byte on the link
  function automatic logic [7:0] t_send(input logic [7:0] op);
    case (op)
      8'h10:        return 8'd1;
      8'h20, 8'h40: return 8'hFF;
      default:      return 8'd0;
    endcase
  endfunction
  function automatic logic [7:0] t_recv(input logic [7:0] op);
    case (op)
      8'h38:   return 8'd4;
      8'h28:   return 8'hFF;
      default: return 8'd0;
    endcase
  endfunction
  assign chk_send = t_send(chk_op);
  assign tbl_send = t_send(tbl_op);
  assign tbl_recv = t_recv(tbl_op);

  int nchk = 0, nfail = 0;
  logic [7:0] txlog [0:511];
  logic [7:0] rxq   [0:1023];
  int txn = 0, rxw = 0, rxr = 0, lat = 2;
  int done_cnt = 0, irq_cnt = 0;

  // link responder
  initial begin
    forever begin
      @(negedge clk);
      link_ack = 1'b0;
      if (link_go) begin
        if (link_dir) begin txlog[txn] = link_tx; txn++; end
        repeat (lat) @(negedge clk);
        link_ack = 1'b1;
        if (!link_dir) begin link_rx = rxq[rxr]; rxr++; end
      end
    end
  end

  always @(negedge clk) begin
    if (done_valid) done_cnt++;
    if (irq_valid)  irq_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rx_put(input logic [7:0] b);
    rxq[rxw] = b; rxw++;
  endtask

  task automatic push(input logic [7:0] op, input logic [5:0] nb,
                      input logic [DW-1:0] d, input logic df);
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1'b1; req_op = op; req_nbytes = nb; req_data = d; req_deferred = df;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int k = 0;
    while (done_cnt < n && k < 3000) begin @(negedge clk); k++; end
    #1;
  endtask
  task automatic wait_irq(input int n);
    int k = 0;
    while (irq_cnt < n && k < 3000) begin @(negedge clk); k++; end
    #1;
  endtask
  task automatic pulse_attn();
    @(negedge clk); attn = 1'b1;
    repeat (3) @(negedge clk);
    attn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 link_go", link_go, 0);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 irq_valid", irq_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 stray", stray_reply, 0);
  endtask

  task automatic t_fixed_send();
    int t0 = txn, d0 = done_cnt;
    push(8'h10, 6'd2, DW'(8'hA5), 1'b0);
    wait_done(d0 + 1);
    chk("R2 opcode", txlog[t0], 8'h10);
    chk("R2 data", txlog[t0+1], 8'hA5);
    chk("R2 count", txn - t0, 2);
    chk("R5 status", done_status, 0);
    chk("R5 len0", done_len, 0);
  endtask

  task automatic t_prefix_send();
    int t0 = txn, d0 = done_cnt;
    push(8'h20, 6'd4, DW'(24'h332211), 1'b0);
    wait_done(d0 + 1);
    chk("R3 opcode", txlog[t0], 8'h20);
    chk("R3 lenbyte", txlog[t0+1], 8'h03);
    chk("R3 bytes", {txlog[t0+2], txlog[t0+3], txlog[t0+4]}, 24'h112233);
    chk("R3 count", txn - t0, 5);
  endtask

  task automatic t_reject();
    int t0 = txn, d0 = done_cnt;
    push(8'h10, 6'd3, '0, 1'b0);
    #1;
    chk("R4 done", done_cnt - d0, 1);
    chk("R4 status", done_status, 1);
    chk("R4 len", done_len, 0);
    push(8'h20, 6'd0, '0, 1'b0);
    #1;
    chk("R4 zero nbytes", done_cnt - d0, 2);
    chk("R4 zero status", done_status, 1);
    repeat (10) @(negedge clk);
    chk("R4 nothing sent", txn - t0, 0);
  endtask

  task automatic t_fixed_reply();
    int d0 = done_cnt;
    rx_put(8'hDE); rx_put(8'hAD); rx_put(8'hBE); rx_put(8'hEF);
    push(8'h38, 6'd1, '0, 1'b0);
    wait_done(d0 + 1);
    chk("R5 status", done_status, 0);
    chk("R5 len", done_len, 4);
    chk("R5 data", done_data[31:0], 32'hEFBEADDE);
  endtask

  task automatic t_prefix_reply();
    int d0 = done_cnt;
    rx_put(8'h02); rx_put(8'h55); rx_put(8'h66);
    push(8'h28, 6'd1, '0, 1'b0);
    wait_done(d0 + 1);
    chk("R6 len", done_len, 2);
    chk("R6 data", done_data[15:0], 16'h6655);
    chk("R6 status", done_status, 0);
  endtask

  task automatic t_overlong();
    int d0 = done_cnt;
    rx_put(8'd34);
    for (int i = 0; i < 34; i++) rx_put(8'(i));
    push(8'h28, 6'd1, '0, 1'b0);
    wait_done(d0 + 1);
    chk("R7 status", done_status, 2);
    chk("R7 len", done_len, 32);
    chk("R7 first", done_data[7:0], 8'h00);
    chk("R7 last", done_data[255:248], 8'd31);
    chk("R7 all consumed", rxr, rxw);
  endtask

  task automatic t_attn();
    int t0 = txn, i0 = irq_cnt;
    rx_put(8'h03); rx_put(8'h08); rx_put(8'h12); rx_put(8'h34);
    pulse_attn();
    wait_irq(i0 + 1);
    chk("R8 iack opcode", txlog[t0], 8'h78);
    chk("R8 irq len", irq_len, 3);
    chk("R8 irq data", irq_data[23:0], 24'h341208);
    chk("R8 irq ovf", irq_ovf, 0);
  endtask

  task automatic t_priority();
    int t0 = txn, d0 = done_cnt, i0 = irq_cnt, k = 0;
    rx_put(8'h01); rx_put(8'h02); rx_put(8'h03); rx_put(8'h04);
    rx_put(8'h01); rx_put(8'h09);
    push(8'h38, 6'd1, '0, 1'b0);
    while (txn == t0 && k < 100) begin @(negedge clk); k++; end
    fork pulse_attn(); join_none
    push(8'h10, 6'd2, DW'(8'h5A), 1'b0);
    wait_done(d0 + 2);
    wait_irq(i0 + 1);
    chk("R9 first", txlog[t0], 8'h38);
    chk("R9 iack before queued", txlog[t0+1], 8'h78);
    chk("R9 queued after", txlog[t0+2], 8'h10);
    chk("R9 irq byte", irq_data[7:0], 8'h09);
  endtask

  task automatic t_fifo();
    int t0 = txn, d0 = done_cnt;
    lat = 40;
    for (int i = 1; i <= 5; i++) push(8'h10, 6'd2, DW'(i), 1'b0);
    #1;
    chk("R10 ready low when full", req_ready, 0);
    lat = 2;
    wait_done(d0 + 5);
    for (int i = 0; i < 5; i++) begin
      chk("R10 order op", txlog[t0 + 2*i], 8'h10);
      chk("R10 order data", txlog[t0 + 2*i + 1], 8'(i + 1));
    end
  endtask

  task automatic t_deferred();
    int t0 = txn, d0 = done_cnt, t1;
    push(8'h40, 6'd2, DW'(8'h07), 1'b1);
    repeat (30) @(negedge clk);
    chk("R11 no early done", done_cnt - d0, 0);
    chk("R11 sent", {txlog[t0], txlog[t0+1], txlog[t0+2]}, 24'h400107);
    push(8'h40, 6'd2, DW'(8'h08), 1'b1);
    repeat (30) @(negedge clk);
    chk("R11 second held", txn - t0, 3);
    // R14: autopoll packet while waiting goes to irq
    rx_put(8'h03); rx_put(8'h14); rx_put(8'h55); rx_put(8'h66);
    begin
      int i0 = irq_cnt;
      pulse_attn();
      wait_irq(i0 + 1);
      chk("R14 irq len", irq_len, 3);
      chk("R14 irq data", irq_data[23:0], 24'h665514);
      chk("R14 no done", done_cnt - d0, 0);
    end
    t1 = txn;
    rx_put(8'h03); rx_put(8'h10); rx_put(8'hAB); rx_put(8'hCD);
    pulse_attn();
    wait_done(d0 + 1);
    chk("R12 len", done_len, 2);
    chk("R12 data", done_data[15:0], 16'hCDAB);
    chk("R11 status", done_status, 0);
    rx_put(8'h02); rx_put(8'h10); rx_put(8'hEE);
    repeat (30) @(negedge clk);
    chk("R11 second started", {txlog[t1+1], txlog[t1+2], txlog[t1+3]}, 24'h400108);
    pulse_attn();
    wait_done(d0 + 2);
    chk("R12 short empty", done_len, 0);
  endtask

  task automatic t_stray();
    int d0 = done_cnt, i0 = irq_cnt;
    rx_put(8'h02); rx_put(8'h10); rx_put(8'h99);
    pulse_attn();
    repeat (60) @(negedge clk);
    chk("R13 stray", stray_reply, 1);
    chk("R13 no done", done_cnt - d0, 0);
    chk("R13 no irq", irq_cnt - i0, 0);
    chk("R13 consumed", rxr, rxw);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_fixed_send();
    t_prefix_send();
    t_reject();
    t_fixed_reply();
    t_prefix_reply();
    t_overlong();
    t_attn();
    t_priority();
    t_fifo();
    t_deferred();
    t_stray();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule